// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns the 16-bit sum and the carry-out. It has no clock, reset or storage, so the outputs follow the inputs after gate delay alone.

The datapath is split into four 4-bit groups. Inside each group, every bit forms a generate term (AND of the operand bits) and a propagate term (XOR of the operand bits). Each carry in the group is written as a flat sum of products over those terms and the group's incoming carry. No carry is built from another computed carry.

Each group also reports a group generate and a group propagate. A second lookahead stage expands the same way over those group signals and the external carry-in. It produces the carry into groups 1 to 3 and the final carry-out, so no carry ripples from one group to the next. Each sum bit is the bit's propagate term XORed with the carry into that bit. Group width and group count are parameters; the defaults give 16 bits.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned numbers, for every input combination.
- R2: `cout_o` equals bit 16 of the unsigned 17-bit result of `a_i + b_i + cin_i`.
- R3: With both operands all ones and `cin_i` = 1, `sum_o` is 16'hFFFF and `cout_o` is 1. With both operands all ones and `cin_i` = 0, `sum_o` is 16'hFFFE and `cout_o` is 1.
- R4: When every bit propagates (`b_i` is the bitwise inverse of `a_i`), the carry-in passes through the whole width. `cin_i` = 0 gives `sum_o` = 16'hFFFF and `cout_o` = 0. `cin_i` = 1 gives `sum_o` = 16'h0000 and `cout_o` = 1.
- R5: The carry into each group boundary (bits 4, 8 and 12) equals bit 4j of the sum of the operand slices below that boundary plus `cin_i`. At the ports, this carry shows up as `sum_o[4j] ^ a_i[4j] ^ b_i[4j]`.
- R6: A group whose four bits all propagate passes its incoming carry unchanged to the next group. A group that generates always sends a carry of 1 to the next group. A group never reports generate and propagate at the same time.
- R7: Alternating bit patterns such as 16'hAAAA and 16'h5555, with either carry-in, produce the sum and carry-out given by R1 and R2.
- R8: All-zero operands with `cin_i` = 0 produce `sum_o` = 0 and `cout_o` = 0. With `cin_i` = 1 they produce `sum_o` = 1 and `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The assertions are evaluated whenever the combinational logic settles. They take for granted that every operand and carry-in bit is a known 0 or 1, and they skip any evaluation in which an input is unknown. The stimulus drives fully known values from the first evaluation onward: seeded random operands and carry-in, plus directed vectors for full propagate chains, all-ones and all-zero operands, and alternating patterns. Inputs change only at the falling clock edge, and outputs are sampled a few nanoseconds later, well before the next change.

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4,
  localparam int W      = GROUP_W * GROUPS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0]      gen, prop, carry;
  logic [GROUPS-1:0] grp_g, grp_p;
  logic [GROUPS:0]   grp_c;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  // Second level: flat expansion over group generate/propagate and cin_i
  always_comb begin
    for (int j = 0; j <= GROUPS; j++) begin
      logic acc, chain;
      chain = 1'b1;
      for (int m = 0; m < j; m++) chain = chain & grp_p[m];
      acc = cin_i & chain;
      for (int k = 0; k < j; k++) begin
        chain = grp_g[k];
        for (int m = k + 1; m < j; m++) chain = chain & grp_p[m];
        acc = acc | chain;
      end
      grp_c[j] = acc;
    end
  end

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    localparam int BASE = gi * GROUP_W;
    logic [GROUP_W-1:0] pg, gg, cg;
    logic               g_out;

    assign pg = prop[BASE +: GROUP_W];
    assign gg = gen[BASE +: GROUP_W];

    // Bit-level carries, each from g, p and the group's incoming carry only
    always_comb begin
      for (int i = 0; i < GROUP_W; i++) begin
        logic acc, chain;
        chain = 1'b1;
        for (int m = 0; m < i; m++) chain = chain & pg[m];
        acc = grp_c[gi] & chain;
        for (int k = 0; k < i; k++) begin
          chain = gg[k];
          for (int m = k + 1; m < i; m++) chain = chain & pg[m];
          acc = acc | chain;
        end
        cg[i] = acc;
      end
    end

    always_comb begin
      logic chain;
      g_out = 1'b0;
      for (int k = 0; k < GROUP_W; k++) begin
        chain = gg[k];
        for (int m = k + 1; m < GROUP_W; m++) chain = chain & pg[m];
        g_out = g_out | chain;
      end
    end

    assign grp_g[gi]               = g_out;
    assign grp_p[gi]               = &pg;
    assign carry[BASE +: GROUP_W]  = cg;

    always_comb begin
      if (!$isunknown({a_i, b_i, cin_i})) begin
        // R6: full propagate passes the incoming carry through
        p_grp_pass_r6: assert (!grp_p[gi] || (grp_c[gi+1] == grp_c[gi]))
          else $error("group %0d propagate did not pass carry", gi);
        // R6: a generating group always sends a carry onward
        p_grp_gen_r6: assert (!grp_g[gi] || grp_c[gi+1])
          else $error("group %0d generate without carry", gi);
        // R6: generate and propagate never both set
        p_grp_excl_r6: assert (!(grp_g[gi] && grp_p[gi]))
          else $error("group %0d generate and propagate both set", gi);
      end
    end

    if (gi > 0) begin : g_chk
      logic [BASE:0] low_sum;
      assign low_sum = {1'b0, a_i[BASE-1:0]} + {1'b0, b_i[BASE-1:0]} + {{BASE{1'b0}}, cin_i};
      always_comb begin
        if (!$isunknown({a_i, b_i, cin_i}))
          // R5: carry into the group matches the arithmetic carry below it
          p_grp_carry_r5: assert (grp_c[gi] == low_sum[BASE])
            else $error("carry into group %0d wrong", gi);
      end
    end
  end

  assign sum_o  = prop ^ carry;
  assign cout_o = grp_c[GROUPS];

  logic [W:0] ref_total;
  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_sum_r1: assert (sum_o == ref_total[W-1:0])
        else $error("sum mismatch");
      p_cout_r2: assert (cout_o == ref_total[W])
        else $error("carry-out mismatch");
    end
  end

endmodule

// File: tb/lookahead_adder_tb.sv
module lookahead_adder_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  lookahead_adder u_dut (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout));

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic ref_bcarry(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input int pos);
    logic [W:0] t;
    logic [W-1:0] mask;
    mask = (16'h1 << pos) - 16'h1;
    t = {1'b0, x & mask} + {1'b0, y & mask} + {{W{1'b0}}, c};
    return t[pos];
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; cin = c;
    #5;
    e = ref_add(x, y, c);
    check({req, "/R1"}, {1'b0, sum}, {1'b0, e[W-1:0]});
    check({req, "/R2"}, {{W{1'b0}}, cout}, {{W{1'b0}}, e[W]});
    for (int j = 4; j < W; j += 4)
      check({req, "/R5"}, {{W{1'b0}}, sum[j] ^ x[j] ^ y[j]},
            {{W{1'b0}}, ref_bcarry(x, y, c, j)});
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    #5;
    check("R8 zero", {cout, sum}, 17'h0);
    apply(16'h0000, 16'h0000, 1'b1, "R8");
    check("R8 one", {cout, sum}, 17'h00001);
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R3");
    check("R3 ones cin1", {cout, sum}, 17'h1FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R3");
    check("R3 ones cin0", {cout, sum}, 17'h1FFFE);
    apply(16'hA5C3, 16'h5A3C, 1'b0, "R4");
    check("R4 chain cin0", {cout, sum}, 17'h0FFFF);
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R4");
    check("R4 chain cin1", {cout, sum}, 17'h10000);
    apply(16'h0000, 16'hFFFF, 1'b1, "R4");
    check("R4 zero/ones", {cout, sum}, 17'h10000);
    apply(16'hAAAA, 16'h5555, 1'b0, "R7");
    apply(16'hAAAA, 16'hAAAA, 1'b1, "R7");
    check("R7 aaaa+aaaa+1", {cout, sum}, 17'h15555);
    apply(16'h5555, 16'h5555, 1'b1, "R7");
    apply(16'h000F, 16'h0001, 1'b0, "R6");
    check("R6 group0 generate", {cout, sum}, 17'h00010);
    apply(16'h0FFF, 16'h0000, 1'b1, "R6");
    check("R6 pass groups", {cout, sum}, 17'h01000);
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "rand");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule